// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a set of device interrupt lines to one processor-side message port. Each line has its own redirection entry with an 8-bit vector, a trigger mode (edge or level) and a mask. When a line raises an interrupt, the block sends one message. The message carries the line's vector and a flag that says whether the line is level-triggered. The message is held on a valid/ready handshake until the processor accepts it. When several lines are waiting at once, the lowest-numbered line goes first.

Level-triggered lines keep an in-service flag. The flag is set when the processor accepts the line's message. It is cleared only by an end-of-interrupt notice whose vector matches the entry. If the line is still high at that point, the block sends the interrupt again. Edge-triggered lines latch a rising edge only while unmasked, so an edge that arrives while the line is masked is lost.

Software reaches every register through a two-slot window: an index slot that selects a register, and a data slot that reads or writes the selected register. The window holds an identifier register with a four-bit writable field, a read-only version register, an arbitration register that shadows the identifier field, and one redirection entry per line.

Top module: `irq_router`

## Requirements
- R1: Register index 0 (identifier) has one writable field, bits 27:24. All other bits read 0 whatever is written. After reset the field is 0.
- R2: Register index 1 (version) is read-only. It reads the version code in bits 7:0 and NUM_LINES-1 in bits 23:16, and a write leaves the readback unchanged.
- R3: Register index 2 (arbitration) reads, in bits 27:24, the last value written to the identifier field. Writes to index 2 have no effect.
- R4: The entry for line n is at index 0x10+2n (low word) and 0x11+2n (high word). Low word fields: vector in bits 7:0, delivery mode in bits 10:8, in-service flag in bit 14, trigger in bit 15 (1 = level, 0 = edge), mask in bit 16. The delivery mode reads 0 and ignores writes; only fixed delivery exists. The in-service flag is read-only. All other low-word bits read 0. The high word reads 0 and ignores writes. Reset leaves every entry masked (low word 0x0001_0000).
- R5: In edge mode, one low-to-high transition on an unmasked line produces exactly one message with msg_level = 0.
- R6: In edge mode, a rising edge that occurs while the entry is masked is discarded. Clearing the mask afterwards delivers nothing.
- R7: In level mode, a high unmasked line produces a message with msg_level = 1. If the line is still high when the matching end-of-interrupt arrives, another message follows. If the line fell before that notice, no message follows.
- R8: The in-service flag of a level entry is set when its message is accepted. It stays set through notices with a different vector and is cleared by a notice carrying the entry's vector.
- R9: In level mode, dropping and re-raising the line while it is in service causes no extra message.
- R10: A level line held high while masked is delivered once the mask is cleared. This includes a line masked during service whose end-of-interrupt arrived while it was masked.
- R11: Edges pending on several lines are all delivered, lowest line number first.
- R12: While msg_valid is high and msg_ready is low, msg_valid, msg_vector and msg_level hold. Each accepted message is delivered exactly once.
- R13: A write with win_sel = 0 loads the index from win_wdata[7:0], and with win_sel = 0 win_rdata returns that index. With win_sel = 1, reads and writes go to the register the index selects. Unknown indices read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Device interrupt lines, synchronous to clk |
| win_we | input | 1 | Window write strobe |
| win_sel | input | 1 | 0 selects the index slot, 1 the data slot |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data (combinational) |
| msg_valid | output | 1 | Interrupt message present |
| msg_ready | input | 1 | Processor accepts the message |
| msg_vector | output | 8 | Vector of the message |
| msg_level | output | 1 | 1 when the message comes from a level-triggered line |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector the notice refers to |

## Verification
The bench builds the block with its default parameters: 24 lines and version code 0x11. With that size it reaches neighbouring lines 14 and 15 for the simultaneous-edge ordering, a mid-table entry for the field layout, and the last entry at index 0x3E as well as the first index past the table. A behavioural model driven by the same stimulus predicts valid, vector and level on every cycle. This covers holding the message through stalls, re-raising after an end-of-interrupt, and the interplay of masking with the in-service flag.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int VEC_W     = 8;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = 8;
  localparam int BIT_INSVC = 14;
  localparam int BIT_LEVEL = 15;
  localparam int BIT_MASK  = 16;

  localparam logic [IDX_W-1:0] IDX_IDENT   = 8'h00;
  localparam logic [IDX_W-1:0] IDX_VERSION = 8'h01;
  localparam logic [IDX_W-1:0] IDX_ARBIT   = 8'h02;
  localparam logic [IDX_W-1:0] IDX_ENTRY0  = 8'h10;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic             level;
    logic             mask;
  } redir_t;

  // Readback image of an entry's low word.
  function automatic logic [WORD_W-1:0] entry_word(redir_t e, logic insvc);
    logic [WORD_W-1:0] w;
    w             = '0;
    w[VEC_W-1:0]  = e.vec;
    w[BIT_INSVC]  = insvc;
    w[BIT_LEVEL]  = e.level;
    w[BIT_MASK]   = e.mask;
    return w;
  endfunction

  // Writable fields taken from a low-word write; delivery mode and status are dropped.
  function automatic redir_t entry_from_word(logic [WORD_W-1:0] w);
    redir_t e;
    e.vec   = w[VEC_W-1:0];
    e.level = w[BIT_LEVEL];
    e.mask  = w[BIT_MASK];
    return e;
  endfunction

  // Identifier and arbitration registers share one layout: a nibble at 27:24.
  function automatic logic [WORD_W-1:0] nibble_word(logic [3:0] f);
    return {4'b0000, f, 24'h000000};
  endfunction

  function automatic logic [WORD_W-1:0] version_word(int lines, logic [7:0] code);
    return {8'h00, 8'(lines - 1), 8'h00, code};
  endfunction

endpackage

// File: rtl/irq_regwin.sv
module irq_regwin
  import irq_router_pkg::*;
#(
  parameter int          NUM_LINES = 24,
  parameter logic [7:0]  VERSION   = 8'h11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_we,
  input  logic                    win_sel,
  input  logic [WORD_W-1:0]       win_wdata,
  output logic [WORD_W-1:0]       win_rdata,
  input  logic [NUM_LINES-1:0]    insvc_i,
  output redir_t [NUM_LINES-1:0]  ent_o
);

  localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [IDX_W-1:0] idx_q;
  logic [3:0]       ident_q;
  logic [3:0]       arbit_q;
  redir_t           ent_q [NUM_LINES];

  logic [IDX_W-1:0] ent_off;
  logic             ent_hit;
  logic             ent_hi;
  logic [SEL_W-1:0] ent_sel;
  logic             data_wr;

  assign ent_off = idx_q - IDX_ENTRY0;
  assign ent_hit = (idx_q >= IDX_ENTRY0) && (ent_off < IDX_W'(2 * NUM_LINES));
  assign ent_hi  = ent_off[0];
  assign ent_sel = ent_off[SEL_W:1];
  assign data_wr = win_we && win_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ident_q <= '0;
      arbit_q <= '0;
    end else if (win_we && !win_sel) begin
      idx_q <= win_wdata[IDX_W-1:0];
    end else if (data_wr && idx_q == IDX_IDENT) begin
      ident_q <= win_wdata[27:24];
      arbit_q <= win_wdata[27:24];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[g] <= '{vec: '0, level: 1'b0, mask: 1'b1};
      end else if (data_wr && ent_hit && !ent_hi && ent_sel == SEL_W'(g)) begin
        ent_q[g] <= entry_from_word(win_wdata);
      end
    end
    assign ent_o[g] = ent_q[g];
  end

  always_comb begin
    win_rdata = '0;
    if (!win_sel) begin
      win_rdata[IDX_W-1:0] = idx_q;
    end else if (idx_q == IDX_IDENT) begin
      win_rdata = nibble_word(ident_q);
    end else if (idx_q == IDX_VERSION) begin
      win_rdata = version_word(NUM_LINES, VERSION);
    end else if (idx_q == IDX_ARBIT) begin
      win_rdata = nibble_word(arbit_q);
    end else if (ent_hit && !ent_hi) begin
      win_rdata = entry_word(ent_q[ent_sel], insvc_i[ent_sel]);
    end
  end

  AST_ARB_SHADOWS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == IDX_IDENT) |=> (arbit_q == $past(win_wdata[27:24]))); // R3
  AST_ARB_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == IDX_ARBIT) |=> $stable(arbit_q)); // R3
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && !win_sel) |=> (idx_q == $past(win_wdata[IDX_W-1:0]))); // R13

endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LINES-1:0]    lines_i,
  input  redir_t [NUM_LINES-1:0]  ent_i,
  input  logic [NUM_LINES-1:0]    launch_oh_i,
  input  logic [NUM_LINES-1:0]    accept_lvl_oh_i,
  input  logic                    eoi_valid_i,
  input  logic [VEC_W-1:0]        eoi_vector_i,
  output logic [NUM_LINES-1:0]    req_o,
  output logic [NUM_LINES-1:0]    insvc_o
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic prev_q;
    logic pend_q;
    logic insvc_q;
    logic rise;
    logic eoi_hit;

    assign rise    = lines_i[g] && !prev_q;
    assign eoi_hit = eoi_valid_i && (eoi_vector_i == ent_i[g].vec);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        pend_q  <= 1'b0;
        insvc_q <= 1'b0;
      end else begin
        prev_q <= lines_i[g];
        if (launch_oh_i[g])                          pend_q <= 1'b0;
        if (rise && !ent_i[g].mask && !ent_i[g].level) pend_q <= 1'b1;
        if (ent_i[g].level)                          pend_q <= 1'b0;
        if (accept_lvl_oh_i[g])  insvc_q <= 1'b1;
        else if (eoi_hit)        insvc_q <= 1'b0;
      end
    end

    assign req_o[g]   = !ent_i[g].mask &&
                        (ent_i[g].level ? (lines_i[g] && !insvc_q) : pend_q);
    assign insvc_o[g] = insvc_q;

    AST_MASKED_EDGE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && ent_i[g].mask && !pend_q) |=> !pend_q); // R6
    AST_INSVC_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept_lvl_oh_i[g] |=> insvc_q); // R8
    AST_INSVC_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(insvc_q) |-> $past(eoi_hit)); // R8
  end

endmodule

// File: rtl/irq_deliver.sv
module irq_deliver
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LINES-1:0]    req_i,
  input  redir_t [NUM_LINES-1:0]  ent_i,
  input  logic                    msg_ready_i,
  output logic                    msg_valid_o,
  output logic [VEC_W-1:0]        msg_vector_o,
  output logic                    msg_level_o,
  output logic [NUM_LINES-1:0]    launch_oh_o,
  output logic [NUM_LINES-1:0]    accept_lvl_oh_o
);

  localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

  logic             vld_q;
  logic [SEL_W-1:0] line_q;
  logic [VEC_W-1:0] vec_q;
  logic             lvl_q;

  logic [NUM_LINES-1:0] inflight;
  logic [NUM_LINES-1:0] elig;
  logic [SEL_W-1:0]     win;
  logic                 any;
  logic                 fire;
  logic                 load;

  assign inflight = vld_q ? (ONE << line_q) : '0;
  assign elig     = req_i & ~inflight;
  assign fire     = vld_q && msg_ready_i;
  assign load     = !vld_q || fire;

  // Lowest line number wins.
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win = SEL_W'(i);
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      line_q <= '0;
      vec_q  <= '0;
      lvl_q  <= 1'b0;
    end else if (load) begin
      vld_q <= any;
      if (any) begin
        line_q <= win;
        vec_q  <= ent_i[win].vec;
        lvl_q  <= ent_i[win].level;
      end
    end
  end

  assign launch_oh_o     = (load && any) ? (ONE << win) : '0;
  assign accept_lvl_oh_o = (fire && lvl_q) ? (ONE << line_q) : '0;
  assign msg_valid_o     = vld_q;
  assign msg_vector_o    = vec_q;
  assign msg_level_o     = lvl_q;

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_vector_o) && $stable(msg_level_o))); // R12
  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_oh_o)); // R11
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|launch_oh_o) |-> ((elig & (launch_oh_o - ONE)) == '0)); // R11

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int         NUM_LINES = 24,
  parameter logic [7:0] VERSION   = 8'h11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_lines,
  input  logic                  win_we,
  input  logic                  win_sel,
  input  logic [31:0]           win_wdata,
  output logic [31:0]           win_rdata,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [7:0]            msg_vector,
  output logic                  msg_level,
  input  logic                  eoi_valid,
  input  logic [7:0]            eoi_vector
);

  redir_t [NUM_LINES-1:0] ent;
  logic   [NUM_LINES-1:0] req;
  logic   [NUM_LINES-1:0] insvc;
  logic   [NUM_LINES-1:0] launch_oh;
  logic   [NUM_LINES-1:0] accept_lvl_oh;

  irq_regwin #(.NUM_LINES(NUM_LINES), .VERSION(VERSION)) u_regwin (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_we    (win_we),
    .win_sel   (win_sel),
    .win_wdata (win_wdata),
    .win_rdata (win_rdata),
    .insvc_i   (insvc),
    .ent_o     (ent)
  );

  irq_line_state #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk             (clk),
    .rst_n           (rst_n),
    .lines_i         (irq_lines),
    .ent_i           (ent),
    .launch_oh_i     (launch_oh),
    .accept_lvl_oh_i (accept_lvl_oh),
    .eoi_valid_i     (eoi_valid),
    .eoi_vector_i    (eoi_vector),
    .req_o           (req),
    .insvc_o         (insvc)
  );

  irq_deliver #(.NUM_LINES(NUM_LINES)) u_deliver (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_i           (req),
    .ent_i           (ent),
    .msg_ready_i     (msg_ready),
    .msg_valid_o     (msg_valid),
    .msg_vector_o    (msg_vector),
    .msg_level_o     (msg_level),
    .launch_oh_o     (launch_oh),
    .accept_lvl_oh_o (accept_lvl_oh)
  );

  AST_LEVEL_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_level) |=> (|insvc)); // R7

endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;

  localparam int N = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_lines = '0;
  logic         win_we = 1'b0;
  logic         win_sel = 1'b0;
  logic [31:0]  win_wdata = '0;
  logic [31:0]  win_rdata;
  logic         msg_valid;
  logic         msg_ready = 1'b1;
  logic [7:0]   msg_vector;
  logic         msg_level;
  logic         eoi_valid = 1'b0;
  logic [7:0]   eoi_vector = '0;

  always #5 clk = ~clk;

  irq_router #(.NUM_LINES(N), .VERSION(8'h11)) u_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .win_we(win_we), .win_sel(win_sel), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_level(msg_level),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R12";

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_vec [N];
  bit m_lvl [N], m_mask [N], m_prev [N], m_pend [N], m_ins [N];
  bit m_v, m_l;
  int m_line, m_vout, m_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vec[i] = 0; m_lvl[i] = 0; m_mask[i] = 1; m_prev[i] = 0; m_pend[i] = 0; m_ins[i] = 0;
      end
      m_v = 0; m_l = 0; m_line = 0; m_vout = 0; m_idx = 0;
    end else begin
      bit req [N];
      bit fire;
      int win;
      fire = m_v && msg_ready;
      win  = -1;
      for (int i = 0; i < N; i++) begin
        req[i] = !m_mask[i] && (m_lvl[i] ? (irq_lines[i] && !m_ins[i]) : m_pend[i]);
        if (win < 0 && req[i] && !(m_v && m_line == i)) win = i;
      end
      if (m_v && !fire) win = -1;
      for (int i = 0; i < N; i++) begin
        bit rise;
        rise = irq_lines[i] && !m_prev[i];
        if (win == i) m_pend[i] = 0;
        if (rise && !m_mask[i] && !m_lvl[i]) m_pend[i] = 1;
        if (m_lvl[i]) m_pend[i] = 0;
        if (fire && m_l && m_line == i) m_ins[i] = 1;
        else if (eoi_valid && eoi_vector == m_vec[i][7:0]) m_ins[i] = 0;
        m_prev[i] = irq_lines[i];
      end
      if (!m_v || fire) begin
        m_v = (win >= 0);
        if (win >= 0) begin
          m_line = win; m_vout = m_vec[win]; m_l = m_lvl[win];
        end
      end
      if (win_we && !win_sel) m_idx = int'(win_wdata[7:0]);
      else if (win_we && m_idx >= 16 && m_idx < 16 + 2 * N && (m_idx % 2) == 0) begin
        m_vec[(m_idx - 16) / 2]  = int'(win_wdata[7:0]);
        m_lvl[(m_idx - 16) / 2]  = win_wdata[15];
        m_mask[(m_idx - 16) / 2] = win_wdata[16];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(msg_valid == m_v, phase, 32'(msg_valid), 32'(m_v));
      if (m_v && msg_valid) begin
        check(msg_vector == 8'(m_vout), phase, 32'(msg_vector), 32'(m_vout));
        check(msg_level == m_l, phase, 32'(msg_level), 32'(m_l));
      end
    end
  end

  // ---------------- delivery log ----------------
  int cnt [256];
  bit lvl_of [256];
  int order_q [$];

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      cnt[msg_vector]++;
      lvl_of[msg_vector] = msg_level;
      order_q.push_back(int'(msg_vector));
    end
  end

  task automatic clear_log();
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    order_q.delete();
  endtask

  // ---------------- access tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_index(input int idx);
    @(negedge clk); win_we = 1; win_sel = 0; win_wdata = 32'(idx);
    @(negedge clk); win_we = 0;
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] d);
    set_index(idx);
    win_we = 1; win_sel = 1; win_wdata = d;
    @(negedge clk); win_we = 0;
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] d);
    set_index(idx);
    win_sel = 1; #1; d = win_rdata;
  endtask

  task automatic cfg(input int line, input int vec, input bit lvl, input bit mask);
    wr_reg(16 + 2 * line, {15'b0, mask, lvl, 7'b0, 8'(vec)});
  endtask

  task automatic drive_line(input int line, input bit v);
    @(negedge clk); irq_lines[line] = v;
  endtask

  task automatic send_eoi(input int vec);
    @(negedge clk); eoi_valid = 1; eoi_vector = 8'(vec);
    @(negedge clk); eoi_valid = 0;
  endtask

  // ---------------- watchdog ----------------
  bit done = 0;
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] r, r0;
    idle(4);
    rst_n = 1;
    idle(2);

    phase = "R4";
    check(msg_valid == 0, "R12", 32'(msg_valid), 0);
    rd_reg(16 + 2 * 5, r);  check(r == 32'h0001_0000, "R4", r, 32'h0001_0000);
    rd_reg(16 + 2 * 23, r); check(r == 32'h0001_0000, "R4", r, 32'h0001_0000);
    rd_reg(16 + 2 * N, r);  check(r == 0, "R13", r, 0);
    wr_reg(16 + 2 * 5, 32'hFFFF_C7A5);
    rd_reg(16 + 2 * 5, r);  check(r == 32'h0001_80A5, "R4", r, 32'h0001_80A5);
    wr_reg(17 + 2 * 5, 32'hFFFF_FFFF);
    rd_reg(17 + 2 * 5, r);  check(r == 0, "R4", r, 0);

    phase = "R13";
    set_index(8'h25); win_sel = 0; #1;
    check(win_rdata == 32'h25, "R13", win_rdata, 32'h25);

    phase = "R2";
    rd_reg(1, r0); check(r0 == 32'h0017_0011, "R2", r0, 32'h0017_0011);
    wr_reg(1, ~r0); rd_reg(1, r); check(r == r0, "R2", r, r0);

    phase = "R1";
    rd_reg(0, r0); check(r0 == 0, "R1", r0, 0);
    wr_reg(0, ~r0); rd_reg(0, r);
    check((r ^ r0) == 32'h0F00_0000, "R1", r ^ r0, 32'h0F00_0000);

    phase = "R3";
    rd_reg(2, r); check(r == 32'h0F00_0000, "R3", r, 32'h0F00_0000);
    wr_reg(2, 0); rd_reg(2, r); check(r == 32'h0F00_0000, "R3", r, 32'h0F00_0000);
    wr_reg(0, 32'h0A00_0000); rd_reg(2, r); check(r == 32'h0A00_0000, "R3", r, 32'h0A00_0000);

    phase = "R5"; clear_log();
    cfg(14, 8'h76, 0, 0);
    drive_line(14, 1); drive_line(14, 0); idle(6);
    check(cnt[8'h76] == 1, "R5", cnt[8'h76], 1);
    check(lvl_of[8'h76] == 0, "R5", 32'(lvl_of[8'h76]), 0);

    phase = "R7"; clear_log();
    cfg(14, 8'h77, 1, 0);
    drive_line(14, 1); idle(6);
    check(cnt[8'h77] == 1, "R7", cnt[8'h77], 1);
    check(lvl_of[8'h77] == 1, "R7", 32'(lvl_of[8'h77]), 1);
    rd_reg(16 + 28, r); check(r[14] == 1, "R8", 32'(r[14]), 1);
    send_eoi(8'h55);
    rd_reg(16 + 28, r); check(r[14] == 1, "R8", 32'(r[14]), 1);
    idle(8); check(cnt[8'h77] == 1, "R7", cnt[8'h77], 1);
    drive_line(14, 0); send_eoi(8'h77); idle(6);
    check(cnt[8'h77] == 1, "R7", cnt[8'h77], 1);
    rd_reg(16 + 28, r); check(r[14] == 0, "R8", 32'(r[14]), 0);

    clear_log();
    cfg(14, 8'h9A, 1, 0);
    drive_line(14, 1); idle(6);
    send_eoi(8'h9A); idle(6);
    check(cnt[8'h9A] == 2, "R7", cnt[8'h9A], 2);
    drive_line(14, 0); send_eoi(8'h9A); idle(6);
    check(cnt[8'h9A] == 2, "R7", cnt[8'h9A], 2);

    phase = "R9"; clear_log();
    cfg(14, 8'h98, 1, 0);
    drive_line(14, 1); idle(6);
    drive_line(14, 0); idle(2); drive_line(14, 1); idle(2); drive_line(14, 0);
    send_eoi(8'h98); idle(6);
    check(cnt[8'h98] == 1, "R9", cnt[8'h98], 1);

    phase = "R11"; clear_log();
    cfg(14, 8'h78, 0, 0); cfg(15, 8'h66, 0, 0);
    @(negedge clk); msg_ready = 0;
    @(negedge clk); irq_lines[15] = 1; irq_lines[14] = 1;
    @(negedge clk); irq_lines[15] = 0; irq_lines[14] = 0;
    idle(5);
    check(msg_valid && msg_vector == 8'h78, "R12", 32'(msg_vector), 32'h78);
    msg_ready = 1; idle(6);
    check(order_q.size() == 2, "R11", order_q.size(), 2);
    if (order_q.size() == 2) begin
      check(order_q[0] == 8'h78, "R11", order_q[0], 32'h78);
      check(order_q[1] == 8'h66, "R11", order_q[1], 32'h66);
    end
    cfg(15, 0, 0, 1);

    phase = "R6"; clear_log();
    cfg(14, 8'h81, 0, 1);
    drive_line(14, 1); drive_line(14, 0);
    cfg(14, 8'h81, 0, 0); idle(6);
    check(cnt[8'h81] == 0, "R6", cnt[8'h81], 0);
    drive_line(14, 1); idle(6);
    check(cnt[8'h81] == 1, "R5", cnt[8'h81], 1);
    drive_line(14, 0);

    phase = "R10"; clear_log();
    cfg(14, 8'h82, 1, 1);
    drive_line(14, 1); idle(6);
    check(cnt[8'h82] == 0, "R10", cnt[8'h82], 0);
    cfg(14, 8'h82, 1, 0); idle(6);
    check(cnt[8'h82] == 1, "R10", cnt[8'h82], 1);
    drive_line(14, 0); send_eoi(8'h82);

    clear_log();
    cfg(14, 8'h83, 1, 0);
    drive_line(14, 1); idle(6);
    check(cnt[8'h83] == 1, "R10", cnt[8'h83], 1);
    cfg(14, 8'h83, 1, 1); send_eoi(8'h83); idle(6);
    check(cnt[8'h83] == 1, "R10", cnt[8'h83], 1);
    cfg(14, 8'h83, 1, 0); idle(6);
    check(cnt[8'h83] == 2, "R10", cnt[8'h83], 2);
    drive_line(14, 0); send_eoi(8'h83); idle(6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule